// File: doc/BRIEF.md
# Parallel-to-Serial Transmitter with Wrap Loopback

This block turns a stream of 10-bit words, already line-coded upstream, into a serial bit stream. It runs on a single bit-rate clock. A one-cycle load strobe arrives once every ten bit clocks and marks the byte clock edge. On that edge the parallel word is taken into a holding register. On the next bit clock the word moves into a shift register, which emits it least significant bit first. Back-to-back words leave no gap in the serial stream.

The serial stream passes through a short fixed delay. It then drives two outputs. The loopback output always carries the stream, so the receiver's input selector can pick it up during diagnostics. The line output carries the same stream in normal operation. When wrap is requested, the line output is forced to a steady logic 1 instead, which keeps the far end from seeing the loopback traffic.

Top module: `sertx_top`

## Requirements
- R1: On a bit clock edge where `load_stb` is 1, `word_in` is taken into the holding register, and that word is the next one serialized.
- R2: The value of `word_in` on cycles where `load_stb` is 0 has no effect on the serial stream.
- R3: Each captured word is emitted as exactly ten serial bits, bit 0 first and bit 9 last, one bit per bit clock.
- R4: The shift register reloads from the holding register on the bit clock after each strobe. With strobes spaced exactly ten cycles apart, the last bit of one word is followed directly by bit 0 of the next.
- R5: Bit 0 of a word appears on the serial outputs after the fifth rising edge that follows the capture edge, counting the capture edge as edge 0.
- R6: While `wrap_en` is 1, `line_out` is 1.
- R7: While `wrap_en` is 0, `line_out` equals the serial stream, which is the value on `loop_out`.
- R8: `loop_out` carries the serial stream whatever the value of `wrap_en`.
- R9: While reset is asserted, both `line_out` and `loop_out` are 1. After reset, the holding and shift registers are zero, so with no strobe the stream settles to 0 once the delay has flushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock; the byte clock is one tenth of it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_stb | input | 1 | One-cycle strobe marking the byte clock edge |
| word_in | input | 10 | Pre-coded parallel word |
| wrap_en | input | 1 | Requests loopback; holds the line output high |
| line_out | output | 1 | Serial output toward the line |
| loop_out | output | 1 | Serial output toward the receiver's loopback input |

## Verification
Two things can happen in the same cycle: the wrap control can change while a word is halfway out, and a new word can be captured and reloaded while the previous word's last bits are still leaving the delay line. The bench sends words on strobes spaced exactly ten cycles apart, so capture, reload and emission always overlap. On some words it toggles `wrap_en` at random on every bit clock. Each emitted bit is compared on `loop_out` against a scoreboard queue. `line_out` is compared in the same cycle against either the constant 1 or the queued bit, depending on the wrap value at that moment.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned WORD_W_DEF  = 10;
  localparam int unsigned LATENCY_DEF = 5;
  localparam int unsigned RST_SYNC_N  = 2;
endpackage

// File: rtl/sertx_capture.sv
module sertx_capture #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] hold_o,
  output logic              ld_o
);
  logic [WORD_W-1:0] hold_q, hold_d;
  logic              ld_q, ld_d;

  always_comb begin
    hold_d = hold_q;
    if (stb) hold_d = din;
    ld_d = stb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      ld_q   <= 1'b0;
    end else begin
      hold_q <= hold_d;
      ld_q   <= ld_d;
    end
  end

  assign hold_o = hold_q;
  assign ld_o   = ld_q;
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] hold,
  output logic [WORD_W-1:0] word_o,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    if (ld) sh_d = hold;
    else    sh_d = {1'b0, sh_q[WORD_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign word_o = sh_q;
  assign bit_o  = sh_q[0];
endmodule

// File: rtl/sertx_delay.sv
module sertx_delay #(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [DEPTH-1:0] st_q, st_d;

  generate
    if (DEPTH == 1) begin : g_single
      always_comb st_d = din;
    end else begin : g_chain
      always_comb st_d = {st_q[DEPTH-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '1;
    else        st_q <= st_d;
  end

  assign dout = st_q[DEPTH-1];
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int unsigned WORD_W  = WORD_W_DEF,
  parameter int unsigned LATENCY = LATENCY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              wrap_en,
  output logic              line_out,
  output logic              loop_out
);
  localparam int unsigned DLY_DEPTH = (LATENCY > 1) ? LATENCY - 1 : 1;

  logic [RST_SYNC_N-1:0] rsync_q;
  logic                  rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[RST_SYNC_N-2:0], 1'b1};
  end
  assign rst_q_n = rsync_q[RST_SYNC_N-1];

  logic [WORD_W-1:0] hold_w, sh_word;
  logic              ld_w, ser_bit, ser_dly;

  sertx_capture #(.WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_q_n), .stb(load_stb), .din(word_in),
    .hold_o(hold_w), .ld_o(ld_w)
  );

  sertx_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_q_n), .ld(ld_w), .hold(hold_w),
    .word_o(sh_word), .bit_o(ser_bit)
  );

  sertx_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk(clk), .rst_n(rst_q_n), .din(ser_bit), .dout(ser_dly)
  );

  assign loop_out = ser_dly;
  assign line_out = wrap_en | ser_dly;
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int unsigned WORD_W = 10
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              stb,
  input logic [WORD_W-1:0] din,
  input logic [WORD_W-1:0] hold,
  input logic              ld,
  input logic [WORD_W-1:0] shreg,
  input logic              wrap_en,
  input logic              line_out,
  input logic              loop_out
);
  AST_CAPTURE_ON_STB: assert property (@(posedge clk) disable iff (!rst_q_n)
    stb |=> hold == $past(din)); // R1
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rst_q_n)
    !stb |=> $stable(hold)); // R2
  AST_SHIFT_LSB: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ld |=> shreg == {1'b0, $past(shreg[WORD_W-1:1])}); // R3
  AST_RELOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld |=> shreg == $past(hold)); // R4
  AST_LD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld |-> $past(stb)); // R4
  AST_LINE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wrap_en |-> line_out == loop_out); // R7
endmodule

bind sertx_top sertx_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .stb(load_stb), .din(word_in),
  .hold(hold_w), .ld(ld_w), .shreg(sh_word), .wrap_en(wrap_en),
  .line_out(line_out), .loop_out(loop_out)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
  localparam int NW = 12;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load_stb;
  logic [9:0] word_in;
  logic       wrap_en;
  logic       line_out, loop_out;

  int   n_run = 0, n_fail = 0;
  bit   exp_q[$];
  logic mon_go = 1'b0, mon_done = 1'b0;

  always #4 clk = ~clk;

  sertx_top u_dut (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .word_in(word_in),
    .wrap_en(wrap_en), .line_out(line_out), .loop_out(loop_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: called at a negedge; mode 0 wrap off, 1 wrap on, 2 wrap random per cycle
  task automatic send_word(input logic [9:0] w, input int mode);
    word_in  = w;
    load_stb = 1'b1;
    wrap_en  = (mode == 2) ? 1'($urandom) : (mode == 1);
    for (int b = 0; b < 10; b++) exp_q.push_back(w[b]);
    mon_go = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      load_stb = 1'b0;
      word_in  = 10'($urandom); // R2 garbage between strobes
      if (mode == 2) wrap_en = 1'($urandom);
    end
    @(negedge clk);
  endtask

  // monitor: bit 0 leaves after edge 5 past the capture edge -> sixth negedge
  initial begin
    wait (mon_go);
    repeat (6) @(negedge clk);
    for (int k = 0; k < NW*10; k++) begin
      bit e;
      e = exp_q.pop_front();
      check("R1 R2 R3 R4 R5 R8 loop_out", loop_out, e);
      if (wrap_en) check("R6 line_out under wrap", line_out, 1'b1);
      else         check("R7 line_out follows stream", line_out, e);
      @(negedge clk);
    end
    mon_done = 1'b1;
  end

  initial begin
    logic [9:0] words [NW];
    int         modes [NW];
    words[0] = 10'h17C; words[1] = 10'h283; words[2] = 10'h3FF;
    words[3] = 10'h000; words[4] = 10'h155; words[5] = 10'h2AA;
    words[6] = 10'h001; words[7] = 10'h200;
    for (int i = 8; i < NW; i++) words[i] = 10'($urandom);
    for (int i = 0; i < NW; i++) modes[i] = i % 3;

    rst_n = 1'b0; load_stb = 1'b0; word_in = 10'h3C5; wrap_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 line_out in reset", line_out, 1'b1);
    check("R9 loop_out in reset", loop_out, 1'b1);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R9 loop_out zero after reset", loop_out, 1'b0);
    check("R9 line_out zero after reset", line_out, 1'b0);
    wrap_en = 1'b1;
    #1 check("R6 line_out wrap idle", line_out, 1'b1);
    check("R8 loop_out wrap idle", loop_out, 1'b0);
    wrap_en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NW; i++) send_word(words[i], modes[i]);
    wait (mon_done);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule